// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block holds two independent down-counters behind a small register bus with combinational reads and single-cycle writes. For each counter, software chooses its count rate: either a one-cycle reference strobe that arrives from outside, or the bus clock divided by two raised to a programmable power. When a counter is at zero and a count tick occurs, the counter has expired. On expiry the counter either reloads from its reload register, which gives periodic operation, or it stays at zero and its enable bit drops, which gives one-shot operation.

Each expiry sets a sticky event flag. That flag drives the timer's interrupt line directly. Software clears a flag by writing a zero to the flag's bit position in the event register. A written one leaves the flag unchanged. A free-running time base is built by loading all ones into both the reload register and the value register with reload enabled. Elapsed ticks are then the bitwise inverse of the count.

Register offsets, in bytes: control 0x00, event flags 0x04, timer 0 reload 0x10, timer 0 value 0x14, timer 1 reload 0x18, timer 1 value 0x1C.

Top module: `twin_down_timer`

## Requirements
- R1: After reset, every register reads as zero and both interrupt outputs are low.
- R2: The control register keeps and returns only its defined bits. These are: bit 0 run timer 0, bit 1 reload timer 0, bit 2 run timer 1, bit 3 reload timer 1, bit 11 reference rate for timer 0, bit 12 reference rate for timer 1, bits 21:19 divider exponent for timer 0, and bits 24:22 divider exponent for timer 1. All other bits read as zero.
- R3: A write to a value register sets that counter on the following clock edge. The write wins over a decrement that would occur in the same cycle.
- R4: With the reference bit clear and a divider exponent n, a running counter decrements once every 2^n bus cycles. The first decrement comes on the 2^n-th edge after the enabling edge, because the divider restarts whenever its timer is stopped.
- R5: With the reference bit set, a running counter decrements only on cycles where the reference strobe is high.
- R6: With reload enabled, a tick that finds the counter at zero loads the reload value. A reload value of R therefore gives a period of R+1 ticks.
- R7: With reload disabled, a tick that finds the counter at zero leaves it at zero and clears the timer's run bit in the control register.
- R8: Every expiry sets the timer's event flag: bit 0 for timer 0, bit 8 for timer 1. Interrupt output k equals the flag of timer k.
- R9: A write to the event register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R10: A read from any unmapped offset returns zero.
- R11: The two timers are independent. A running timer changes neither the value nor the flag of the other timer.
- R12: With all ones loaded into both the reload and value registers, reload enabled and a divider exponent of 0, the inverse of the value register after k cycles equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | High for a write when bus_en is high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ref_tick | input | 1 | One-cycle reference rate strobe |
| irq | output | 2 | Per-timer interrupt, equal to the event flags |

## Verification
The bench uses the default parameters: 32-bit counters and a 6-bit address bus. With 32-bit counters, the all-ones free-running case and its inverse readout are reachable, and full-width reload values can be written and read back. The 3-bit divider exponents are run at 0, which ticks every cycle and makes periodic and one-shot expiry visible within a few cycles, and at 2, which makes both the divide-by-four spacing and the divider restart after a stop observable. The reference-rate path is driven by single strobes between long idle stretches.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int NCH   = 2;
  localparam int PRE_W = 3;
  localparam int BUS_W = 32;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;

  // control fields per channel
  function automatic int run_bit(int k);    return 2 * k;          endfunction
  function automatic int rl_bit(int k);     return 2 * k + 1;      endfunction
  function automatic int ref_bit(int k);    return 11 + k;         endfunction
  function automatic int div_lsb(int k);    return 19 + PRE_W * k; endfunction
  function automatic int stat_bit(int k);   return 8 * k;          endfunction
  function automatic int off_reload(int k); return 'h10 + 8 * k;   endfunction
  function automatic int off_value(int k);  return 'h14 + 8 * k;   endfunction

  localparam logic [BUS_W-1:0] CTRL_MASK = 32'h01F8_180F;

  typedef struct packed {
    logic             run;
    logic             auto_rl;
    logic             use_ref;
    logic [PRE_W-1:0] div;
  } chan_cfg_t;
endpackage

// File: rtl/twin_timer_prescale.sv
module twin_timer_prescale
  import twin_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  localparam int CW = (1 << PRE_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask  = ~({CW{1'b1}} << div);
    tick  = run & (&(cnt_q | ~mask));
    cnt_d = run ? cnt_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/twin_timer_chan.sv
module twin_timer_chan
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             ref_tick,
  input  logic             wr_reload,
  input  logic             wr_value,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] value_q,
  output logic             expire,
  output logic             stop
);
  logic             pre_tick, tick, at_zero;
  logic [CNT_W-1:0] reload_d, value_d;

  twin_timer_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (cfg.run),
    .div  (cfg.div),
    .tick (pre_tick)
  );

  always_comb begin
    tick     = cfg.run & (cfg.use_ref ? ref_tick : pre_tick);
    at_zero  = (value_q == '0);
    expire   = tick & at_zero & ~wr_value;
    stop     = expire & ~cfg.auto_rl;
    reload_d = wr_reload ? wdata : reload_q;
    value_d  = value_q;
    if (wr_value)
      value_d = wdata;
    else if (tick) begin
      if (!at_zero)        value_d = value_q - CNT_W'(1);
      else if (cfg.auto_rl) value_d = reload_q;
      else                  value_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      value_q  <= '0;
    end else begin
      reload_q <= reload_d;
      value_q  <= value_d;
    end
  end

  // R3
  value_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_value |=> value_q == $past(wdata));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg.auto_rl && !wr_reload) |=> value_q == $past(reload_q));
  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg.auto_rl) |=> value_q == '0);
endmodule

// File: rtl/twin_timer_status.sv
module twin_timer_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         wr,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  always_comb begin
    for (int k = 0; k < N; k++)
      flag_d[k] = set[k] | (flag_q[k] & ~(wr & ~keep[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[k] |=> flag_q[k]);
    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !keep[k] && !set[k]) |=> !flag_q[k]);
  end
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import twin_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic [NCH-1:0]    irq
);
  logic [1:0]        rst_pipe;
  logic              srst_n;
  logic              wr, wr_ctrl, wr_stat;
  logic [31:0]       ctrl_q, ctrl_d;
  logic [NCH-1:0]    expire, stop, keep, flags, wr_rld, wr_val;
  logic [CNT_W-1:0]  rld_v [NCH];
  logic [CNT_W-1:0]  val_v [NCH];
  chan_cfg_t         cfg [NCH];

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  assign wr      = bus_en & bus_wr;
  assign wr_ctrl = wr & (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = wr & (bus_addr == ADDR_W'(OFF_STAT));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)
      ctrl_d = bus_wdata & CTRL_MASK;
    else
      for (int k = 0; k < NCH; k++)
        if (stop[k]) ctrl_d[run_bit(k)] = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign cfg[k].run     = ctrl_q[run_bit(k)];
    assign cfg[k].auto_rl = ctrl_q[rl_bit(k)];
    assign cfg[k].use_ref = ctrl_q[ref_bit(k)];
    assign cfg[k].div     = ctrl_q[div_lsb(k) +: PRE_W];
    assign wr_rld[k]      = wr & (bus_addr == ADDR_W'(off_reload(k)));
    assign wr_val[k]      = wr & (bus_addr == ADDR_W'(off_value(k)));
    assign keep[k]        = bus_wdata[stat_bit(k)];

    twin_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (srst_n),
      .cfg      (cfg[k]),
      .ref_tick (ref_tick),
      .wr_reload(wr_rld[k]),
      .wr_value (wr_val[k]),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .reload_q (rld_v[k]),
      .value_q  (val_v[k]),
      .expire   (expire[k]),
      .stop     (stop[k])
    );

    // R7
    run_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (stop[k] && !wr_ctrl) |=> !ctrl_q[run_bit(k)]);
  end

  twin_timer_status #(.N(NCH)) u_stat (
    .clk  (clk),
    .rst_n(srst_n),
    .set  (expire),
    .wr   (wr_stat),
    .keep (keep),
    .flags(flags)
  );

  assign irq = flags;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_STAT))
      for (int k = 0; k < NCH; k++) bus_rdata[stat_bit(k)] = flags[k];
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == ADDR_W'(off_reload(k))) bus_rdata = 32'(rld_v[k]);
      if (bus_addr == ADDR_W'(off_value(k)))  bus_rdata = 32'(val_v[k]);
    end
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq[0]) |-> $past(expire[0]));
endmodule

// File: tb/twin_down_timer_test.sv
module twin_down_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  twin_down_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // register file vectors: R2 control masking, R10 unmapped reads
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h00, 32'hFFFF_FFFA, 32'h0},
    '{1'b0, 6'h00, 32'h0,         32'h01F8_180A},
    '{1'b1, 6'h10, 32'h1234_5678, 32'h0},
    '{1'b0, 6'h10, 32'h0,         32'h1234_5678},
    '{1'b1, 6'h18, 32'hCAFE_F00D, 32'h0},
    '{1'b0, 6'h18, 32'h0,         32'hCAFE_F00D},
    '{1'b1, 6'h14, 32'hA5A5_A5A5, 32'h0},
    '{1'b0, 6'h14, 32'h0,         32'hA5A5_A5A5},
    '{1'b1, 6'h1C, 32'h0000_0007, 32'h0},
    '{1'b0, 6'h1C, 32'h0,         32'h0000_0007},
    '{1'b0, 6'h08, 32'h0,         32'h0},
    '{1'b0, 6'h3C, 32'h0,         32'h0},
    '{1'b0, 6'h20, 32'h0,         32'h0},
    '{1'b0, 6'h04, 32'h0,         32'h0},
    '{1'b1, 6'h00, 32'h0000_0000, 32'h0},
    '{1'b0, 6'h00, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the following negedge
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] e);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg("R1 ctrl", 6'h00, 32'h0);
    expect_reg("R1 stat", 6'h04, 32'h0);
    expect_reg("R1 value0", 6'h14, 32'h0);
    expect_reg("R1 reload1", 6'h18, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // table walk (R2, R10)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else expect_reg($sformatf("R2/R10 vec %0d", i), VEC[i].addr, VEC[i].exp);
    end

    // R4 prescaled rate, exponent 2
    bus_write(6'h14, 32'd100);
    bus_write(6'h00, 32'h0010_0001);
    repeat (3) @(negedge clk);
    expect_reg("R4 before 4th edge", 6'h14, 32'd100);
    @(negedge clk);
    expect_reg("R4 first decrement", 6'h14, 32'd99);
    repeat (4) @(negedge clk);
    expect_reg("R4 second decrement", 6'h14, 32'd98);
    expect_reg("R11 timer1 untouched", 6'h1C, 32'd7);
    repeat (2) @(negedge clk);
    bus_write(6'h00, 32'h0);
    bus_write(6'h00, 32'h0010_0001);
    repeat (3) @(negedge clk);
    expect_reg("R4 divider restarted", 6'h14, 32'd98);
    @(negedge clk);
    expect_reg("R4 after restart", 6'h14, 32'd97);
    bus_write(6'h00, 32'h0);

    // R5 reference strobe rate on timer 1
    bus_write(6'h1C, 32'd5);
    bus_write(6'h00, 32'h0000_1004);
    repeat (3) @(negedge clk);
    expect_reg("R5 no strobe", 6'h1C, 32'd5);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    expect_reg("R5 one strobe", 6'h1C, 32'd4);
    expect_reg("R11 timer0 held", 6'h14, 32'd97);
    repeat (5) @(negedge clk);
    expect_reg("R5 idle", 6'h1C, 32'd4);
    bus_write(6'h00, 32'h0);

    // R6 periodic reload, R8 flag and irq
    bus_write(6'h10, 32'd2);
    bus_write(6'h14, 32'd1);
    bus_write(6'h00, 32'h0000_0003);
    @(negedge clk);
    expect_reg("R6 at zero", 6'h14, 32'd0);
    check("R8 no irq yet", 32'(irq), 32'h0);
    @(negedge clk);
    expect_reg("R6 reloaded", 6'h14, 32'd2);
    expect_reg("R8 flag0", 6'h04, 32'h0000_0001);
    check("R8 irq0", 32'(irq), 32'h1);
    repeat (3) @(negedge clk);
    expect_reg("R6 period R+1", 6'h14, 32'd2);
    bus_write(6'h00, 32'h0);

    // R7 one-shot on timer 1
    bus_write(6'h1C, 32'd1);
    bus_write(6'h00, 32'h0000_0004);
    repeat (2) @(negedge clk);
    expect_reg("R7 value zero", 6'h1C, 32'd0);
    expect_reg("R7 run bit cleared", 6'h00, 32'h0);
    expect_reg("R8 both flags", 6'h04, 32'h0000_0101);
    check("R8 both irq", 32'(irq), 32'h3);
    repeat (3) @(negedge clk);
    expect_reg("R7 holds zero", 6'h1C, 32'd0);

    // R9 write-zero-to-clear
    bus_write(6'h04, 32'h0000_0100);
    expect_reg("R9 clear bit0 keep bit8", 6'h04, 32'h0000_0100);
    check("R9 irq", 32'(irq), 32'h2);
    bus_write(6'h04, 32'hFFFF_FEFF);
    expect_reg("R9 clear bit8", 6'h04, 32'h0);
    check("R9 irq clear", 32'(irq), 32'h0);

    // R3 value write overrides decrement
    bus_write(6'h14, 32'd40);
    bus_write(6'h00, 32'h0000_0001);
    repeat (2) @(negedge clk);
    expect_reg("R3 running", 6'h14, 32'd38);
    bus_write(6'h14, 32'd50);
    expect_reg("R3 override", 6'h14, 32'd50);
    @(negedge clk);
    expect_reg("R3 resumes", 6'h14, 32'd49);
    bus_write(6'h00, 32'h0);

    // R12 free-running source
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_write(6'h14, 32'hFFFF_FFFF);
    bus_write(6'h00, 32'h0000_0003);
    repeat (10) @(negedge clk);
    bus_read(6'h14, d);
    check("R12 elapsed 10", ~d, 32'd10);
    repeat (20) @(negedge clk);
    bus_read(6'h14, d);
    check("R12 elapsed 30", ~d, 32'd30);
    bus_write(6'h00, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule